// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative translation buffer that turns a 32-bit virtual address into a physical address. Every entry maps two adjacent pages, an even one and an odd one, that share one virtual tag. A per-entry size mask widens both pages together, so the address bit that picks between the two halves moves with the page size. Each half has its own frame number, valid bit and dirty bit. Each entry is either global or bound to one 8-bit address-space identifier.

A lookup presents the address, an access-is-write flag and the current identifier. One cycle later a strobe marks a registered response. The response carries the physical address, read and write grants, and a result code. A hit can still report an invalid half, or a write to a clean half. A simple indexed write port loads entries, one per cycle.

Top module: `pair_tlb`

## Requirements
- R1: After reset `rsp_valid_o` is 0, `pa_o` is 0, both grants are 0, and every entry holds all-zero fields.
- R2: An entry hits when its global bit is set or its stored identifier equals `asid_i`, and its tag agrees with `va_i[31:13]` on every bit not ignored by its mask.
- R3: Address bits 12:0 never take part in the tag compare. Bit k of an entry's mask field makes address bit k+13 ignored as well. A mask of 0 gives 4 KiB pages, and a mask of 3 gives 16 KiB pages.
- R4: The half is chosen by the address bit just above the per-page offset, which is bit 12 plus the number of set mask bits. A value of 0 selects the even half (frame 0) and 1 selects the odd half (frame 1).
- R5: A hit on a half whose valid bit is clear returns INVALID, for reads and writes alike.
- R6: A write that hits a valid half whose dirty bit is clear returns DIRTY. A write to a valid dirty half returns MATCH with write granted. Reads never need the dirty bit.
- R7: On MATCH, `pa_o` is the selected frame number shifted up by 12, ORed with the address bits below the selected half's size. Read is always granted, and write is granted exactly when the selected dirty bit is set.
- R8: The result codes are MATCH=0, NOMATCH=1, INVALID=2, DIRTY=3 and BADADDR=4. NOMATCH is returned when no entry hits. This unit never returns BADADDR, which is reserved for upstream segment checks.
- R9: When several entries hit, the lowest-indexed one decides the result.
- R10: A request in cycle n produces `rsp_valid_o` in cycle n+1 only. Without a request there is no strobe.
- R11: A write takes effect for lookups issued from the next cycle onward. A lookup issued in the same cycle as a write sees the entry's previous contents.
- R12: For any result other than MATCH, `pa_o` is 0 and both grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| we_i | input | 1 | Access is a write |
| asid_i | input | 8 | Current address-space identifier |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn_i | input | 19 | Tag, virtual address bits 31:13 |
| wr_mask_i | input | 19 | Size mask, bit k ignores address bit k+13 |
| wr_asid_i | input | 8 | Entry identifier |
| wr_g_i | input | 1 | Entry global bit |
| wr_pfn0_i | input | PA_W-12 | Even-half frame number |
| wr_v0_i | input | 1 | Even-half valid |
| wr_d0_i | input | 1 | Even-half dirty (writable) |
| wr_pfn1_i | input | PA_W-12 | Odd-half frame number |
| wr_v1_i | input | 1 | Odd-half valid |
| wr_d1_i | input | 1 | Odd-half dirty (writable) |
| rsp_valid_o | output | 1 | Response strobe |
| pa_o | output | PA_W | Physical address |
| rd_ok_o | output | 1 | Read granted |
| wr_ok_o | output | 1 | Write granted |
| result_o | output | 3 | Result code |

## Verification
An entry write and a lookup of that same entry can land in the same cycle. The bench provokes this by issuing a write that installs a fresh mapping in the same cycle as a lookup of the address it covers. The response to that lookup must be NOMATCH, because the lookup sees the old contents. A lookup of the same address in the following cycle must return MATCH with the new frame. Both responses are queued on the scoreboard with expected values computed by hand, so a store that forwards the write, or one that delays it a further cycle, shows up as a mismatch.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 13;            // pair of minimum pages
  localparam int PG_W   = OFS_W - 1;     // minimum page offset
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int ASID_W = 8;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3,
    RES_BADADDR = 3'd4
  } res_e;
endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [IDX_W-1:0]                      wr_idx_i,
  input  logic [VPN_W-1:0]                      wr_vpn_i,
  input  logic [VPN_W-1:0]                      wr_mask_i,
  input  logic [ASID_W-1:0]                     wr_asid_i,
  input  logic                                  wr_g_i,
  input  logic [1:0][PFN_W-1:0]                 wr_pfn_i,
  input  logic [1:0]                            wr_v_i,
  input  logic [1:0]                            wr_d_i,
  output logic [NUM_ENT-1:0][VPN_W-1:0]         vpn_o,
  output logic [NUM_ENT-1:0][VPN_W-1:0]         mask_o,
  output logic [NUM_ENT-1:0][ASID_W-1:0]        asid_o,
  output logic [NUM_ENT-1:0]                    g_o,
  output logic [NUM_ENT-1:0][1:0][PFN_W-1:0]    pfn_o,
  output logic [NUM_ENT-1:0][1:0]               v_o,
  output logic [NUM_ENT-1:0][1:0]               d_o
);
  logic wr_hit;
  assign wr_hit = wr_en_i && (32'(wr_idx_i) < NUM_ENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_o  <= '0;
      mask_o <= '0;
      asid_o <= '0;
      g_o    <= '0;
      pfn_o  <= '0;
      v_o    <= '0;
      d_o    <= '0;
    end else if (wr_hit) begin
      vpn_o[wr_idx_i]  <= wr_vpn_i;
      mask_o[wr_idx_i] <= wr_mask_i;
      asid_o[wr_idx_i] <= wr_asid_i;
      g_o[wr_idx_i]    <= wr_g_i;
      pfn_o[wr_idx_i]  <= wr_pfn_i;
      v_o[wr_idx_i]    <= wr_v_i;
      d_o[wr_idx_i]    <= wr_d_i;
    end
  end

  p_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (vpn_o[$past(wr_idx_i)] == $past(wr_vpn_i)) &&
               (pfn_o[$past(wr_idx_i)] == $past(wr_pfn_i)));
endmodule

// File: rtl/pair_tlb_match.sv
module pair_tlb_match
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic [VA_W-1:0]                va_i,
  input  logic [ASID_W-1:0]              asid_i,
  input  logic [NUM_ENT-1:0][VPN_W-1:0]  vpn_i,
  input  logic [NUM_ENT-1:0][VPN_W-1:0]  mask_i,
  input  logic [NUM_ENT-1:0][ASID_W-1:0] asid_e_i,
  input  logic [NUM_ENT-1:0]             g_i,
  output logic [NUM_ENT-1:0]             hit_o
);
  logic [VPN_W-1:0] va_tag;
  assign va_tag = va_i[VA_W-1:OFS_W];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic id_ok, tag_ok;
    assign id_ok  = g_i[i] || (asid_e_i[i] == asid_i);
    assign tag_ok = ((va_tag ^ vpn_i[i]) & ~mask_i[i]) == '0;
    assign hit_o[i] = id_ok && tag_ok;
  end
endmodule

// File: rtl/pair_tlb_resolve.sv
module pair_tlb_resolve
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int PFN_W   = 20,
  parameter int PA_W    = PFN_W + PG_W
) (
  input  logic [VA_W-1:0]                    va_i,
  input  logic                               we_i,
  input  logic [NUM_ENT-1:0]                 hit_i,
  input  logic [NUM_ENT-1:0][VPN_W-1:0]      mask_i,
  input  logic [NUM_ENT-1:0][1:0][PFN_W-1:0] pfn_i,
  input  logic [NUM_ENT-1:0][1:0]            v_i,
  input  logic [NUM_ENT-1:0][1:0]            d_i,
  output logic [PA_W-1:0]                    pa_o,
  output logic                               rd_o,
  output logic                               wr_o,
  output res_e                               res_o
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [IDX_W-1:0] win;
  logic             any;

  // lowest index wins
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        win = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  logic [VA_W-1:0]  full, top_bit, half;
  logic             odd, sel_v, sel_d;
  logic [PFN_W-1:0] sel_pfn;

  assign full    = {mask_i[win], {OFS_W{1'b1}}};
  assign top_bit = full & ~(full >> 1);
  assign half    = full >> 1;
  assign odd     = |(va_i & top_bit);
  assign sel_pfn = pfn_i[win][odd];
  assign sel_v   = v_i[win][odd];
  assign sel_d   = d_i[win][odd];

  always_comb begin
    pa_o  = '0;
    rd_o  = 1'b0;
    wr_o  = 1'b0;
    res_o = RES_MATCH;
    if (!any)                res_o = RES_NOMATCH;
    else if (!sel_v)         res_o = RES_INVALID;
    else if (we_i && !sel_d) res_o = RES_DIRTY;
    else begin
      pa_o = {sel_pfn, {PG_W{1'b0}}} | PA_W'(va_i & half);
      rd_o = 1'b1;
      wr_o = sel_d;
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int PA_W    = 32,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [31:0]           va_i,
  input  logic                  we_i,
  input  logic [7:0]            asid_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [18:0]           wr_vpn_i,
  input  logic [18:0]           wr_mask_i,
  input  logic [7:0]            wr_asid_i,
  input  logic                  wr_g_i,
  input  logic [PA_W-13:0]      wr_pfn0_i,
  input  logic                  wr_v0_i,
  input  logic                  wr_d0_i,
  input  logic [PA_W-13:0]      wr_pfn1_i,
  input  logic                  wr_v1_i,
  input  logic                  wr_d1_i,
  output logic                  rsp_valid_o,
  output logic [PA_W-1:0]       pa_o,
  output logic                  rd_ok_o,
  output logic                  wr_ok_o,
  output logic [2:0]            result_o
);
  localparam int PFN_W = PA_W - PG_W;

  logic [NUM_ENT-1:0][VPN_W-1:0]      e_vpn, e_mask;
  logic [NUM_ENT-1:0][ASID_W-1:0]     e_asid;
  logic [NUM_ENT-1:0]                 e_g, hit;
  logic [NUM_ENT-1:0][1:0][PFN_W-1:0] e_pfn;
  logic [NUM_ENT-1:0][1:0]            e_v, e_d;

  pair_tlb_store #(.NUM_ENT(NUM_ENT), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_mask_i,
    .wr_asid_i, .wr_g_i,
    .wr_pfn_i ({wr_pfn1_i, wr_pfn0_i}),
    .wr_v_i   ({wr_v1_i, wr_v0_i}),
    .wr_d_i   ({wr_d1_i, wr_d0_i}),
    .vpn_o (e_vpn), .mask_o (e_mask), .asid_o (e_asid), .g_o (e_g),
    .pfn_o (e_pfn), .v_o (e_v), .d_o (e_d)
  );

  pair_tlb_match #(.NUM_ENT(NUM_ENT)) u_match (
    .va_i, .asid_i, .vpn_i (e_vpn), .mask_i (e_mask),
    .asid_e_i (e_asid), .g_i (e_g), .hit_o (hit)
  );

  logic [PA_W-1:0] pa_c;
  logic            rd_c, wr_c;
  res_e            res_c;

  pair_tlb_resolve #(.NUM_ENT(NUM_ENT), .PFN_W(PFN_W), .PA_W(PA_W)) u_resolve (
    .va_i, .we_i, .hit_i (hit), .mask_i (e_mask), .pfn_i (e_pfn),
    .v_i (e_v), .d_i (e_d), .pa_o (pa_c), .rd_o (rd_c), .wr_o (wr_c),
    .res_o (res_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      pa_o        <= '0;
      rd_ok_o     <= 1'b0;
      wr_ok_o     <= 1'b0;
      result_o    <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        pa_o     <= pa_c;
        rd_ok_o  <= rd_c;
        wr_ok_o  <= wr_c;
        result_o <= res_c;
      end
    end
  end

  p_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_clear_on_fault_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o != RES_MATCH) |-> (pa_o == '0 && !rd_ok_o && !wr_ok_o));
  p_read_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == RES_MATCH) |-> rd_ok_o);
  p_write_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (result_o == RES_MATCH) -> wr_ok_o);
  p_no_badaddr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (result_o != RES_BADADDR));
endmodule

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb_top;
  localparam int NUM_ENT = 16;
  localparam int PA_W    = 32;
  localparam int IDX_W   = $clog2(NUM_ENT);

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic             req_i = 0, we_i = 0, wr_en_i = 0;
  logic [31:0]      va_i = '0;
  logic [7:0]       asid_i = '0, wr_asid_i = '0;
  logic [IDX_W-1:0] wr_idx_i = '0;
  logic [18:0]      wr_vpn_i = '0, wr_mask_i = '0;
  logic             wr_g_i = 0, wr_v0_i = 0, wr_d0_i = 0, wr_v1_i = 0, wr_d1_i = 0;
  logic [19:0]      wr_pfn0_i = '0, wr_pfn1_i = '0;
  logic             rsp_valid_o, rd_ok_o, wr_ok_o;
  logic [31:0]      pa_o;
  logic [2:0]       result_o;

  pair_tlb #(.NUM_ENT(NUM_ENT), .PA_W(PA_W)) dut_i (
    .clk_i(clk), .rst_ni, .req_i, .va_i, .we_i, .asid_i, .wr_en_i, .wr_idx_i,
    .wr_vpn_i, .wr_mask_i, .wr_asid_i, .wr_g_i, .wr_pfn0_i, .wr_v0_i, .wr_d0_i,
    .wr_pfn1_i, .wr_v1_i, .wr_d1_i, .rsp_valid_o, .pa_o, .rd_ok_o, .wr_ok_o,
    .result_o
  );

  localparam logic [2:0] C_MATCH = 3'd0, C_NOMATCH = 3'd1, C_INVALID = 3'd2, C_DIRTY = 3'd3;

  typedef struct {
    logic [31:0] pa;
    logic        rd, wr;
    logic [2:0]  res;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", $sformatf("unexpected strobe act=1 exp=0"));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(pa_o == e.pa && rd_ok_o == e.rd && wr_ok_o == e.wr && result_o == e.res, e.tag,
              $sformatf("act pa=%h rd=%0b wr=%0b res=%0d exp pa=%h rd=%0b wr=%0b res=%0d",
                        pa_o, rd_ok_o, wr_ok_o, result_o, e.pa, e.rd, e.wr, e.res));
      end
    end
  end

  task automatic drive_wr(int idx, logic [18:0] vpn, logic [18:0] msk, logic [7:0] id, logic g,
                          logic [19:0] p0, logic v0, logic d0, logic [19:0] p1, logic v1, logic d1);
    wr_en_i = 1; wr_idx_i = IDX_W'(idx); wr_vpn_i = vpn; wr_mask_i = msk;
    wr_asid_i = id; wr_g_i = g; wr_pfn0_i = p0; wr_v0_i = v0; wr_d0_i = d0;
    wr_pfn1_i = p1; wr_v1_i = v1; wr_d1_i = d1;
  endtask

  task automatic drive_rq(logic [31:0] va, logic we, logic [7:0] id,
                          logic [31:0] pa, logic rd, logic wr, logic [2:0] res, string tag);
    exp_t e;
    req_i = 1; va_i = va; we_i = we; asid_i = id;
    e.pa = pa; e.rd = rd; e.wr = wr; e.res = res; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic load(int idx, logic [18:0] vpn, logic [18:0] msk, logic [7:0] id, logic g,
                      logic [19:0] p0, logic v0, logic d0, logic [19:0] p1, logic v1, logic d1);
    @(negedge clk);
    req_i = 0;
    drive_wr(idx, vpn, msk, id, g, p0, v0, d0, p1, v1, d1);
  endtask

  task automatic look(logic [31:0] va, logic we, logic [7:0] id,
                      logic [31:0] pa, logic rd, logic wr, logic [2:0] res, string tag);
    @(negedge clk);
    wr_en_i = 0;
    drive_rq(va, we, id, pa, rd, wr, res, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_i = 0; wr_en_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rsp_valid_o == 0 && pa_o == 0 && rd_ok_o == 0 && wr_ok_o == 0, "R1",
          $sformatf("act v=%0b pa=%h rd=%0b wr=%0b exp all 0", rsp_valid_o, pa_o, rd_ok_o, wr_ok_o));
    rst_ni = 1;
    // R1: cleared entries miss for a non-zero identifier
    look(32'h0000_0100, 0, 8'h21, 0, 0, 0, C_NOMATCH, "R1");

    load(0, 19'h00200, 19'h0, 8'h05, 0, 20'h12345, 1, 1, 20'h23456, 1, 0);
    load(1, 19'h08000, 19'h3, 8'h09, 1, 20'h40000, 1, 0, 20'h50004, 0, 0);
    load(2, 19'h10000, 19'h0, 8'h03, 0, 20'h11111, 1, 1, 20'h0, 0, 0);
    load(5, 19'h10000, 19'h0, 8'h77, 1, 20'h22222, 1, 1, 20'h0, 0, 0);

    look(32'h0040_0ABC, 0, 8'h05, 32'h1234_5ABC, 1, 1, C_MATCH,   "R4 R7 even");
    look(32'h0040_0ABC, 1, 8'h05, 32'h1234_5ABC, 1, 1, C_MATCH,   "R6 dirty write");
    look(32'h0040_1ABC, 0, 8'h05, 32'h2345_6ABC, 1, 0, C_MATCH,   "R4 R7 odd");
    look(32'h0040_1ABC, 1, 8'h05, 32'h0,         0, 0, C_DIRTY,   "R6 R12 clean write");
    look(32'h0040_0ABC, 0, 8'h06, 32'h0,         0, 0, C_NOMATCH, "R2 R8 asid");
    look(32'h1000_2345, 0, 8'h07, 32'h4000_2345, 1, 0, C_MATCH,   "R2 R3 global 16K");
    look(32'h1000_3FFF, 0, 8'h07, 32'h4000_3FFF, 1, 0, C_MATCH,   "R3 R7 offset");
    look(32'h1000_6000, 0, 8'h07, 32'h0,         0, 0, C_INVALID, "R4 R5 read");
    look(32'h1000_6000, 1, 8'h07, 32'h0,         0, 0, C_INVALID, "R5 write");
    look(32'h1000_2345, 1, 8'h07, 32'h0,         0, 0, C_DIRTY,   "R6 16K");
    look(32'h1000_8000, 0, 8'h07, 32'h0,         0, 0, C_NOMATCH, "R3 R8 tag");
    look(32'h2000_0010, 0, 8'h03, 32'h1111_1010, 1, 1, C_MATCH,   "R9 low index");
    look(32'h2000_0010, 0, 8'h04, 32'h2222_2010, 1, 1, C_MATCH,   "R9 R2 only global");

    // R11: write and lookup of the same mapping in one cycle
    @(negedge clk);
    drive_wr(3, 19'h18000, 19'h0, 8'h03, 0, 20'h33333, 1, 1, 20'h0, 0, 0);
    drive_rq(32'h3000_0000, 0, 8'h03, 32'h0, 0, 0, C_NOMATCH, "R11 same cycle");
    look(32'h3000_0000, 0, 8'h03, 32'h3333_3000, 1, 1, C_MATCH, "R11 next cycle");

    idle();
    idle();
    check(rsp_valid_o == 0, "R10", $sformatf("idle strobe act=%0b exp=0", rsp_valid_o));
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10", $sformatf("pending act=%0d exp=0", exp_q.size()));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10: watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule